// File: doc/BRIEF.md
# Indirect-Access Control and Status Register Block

This block is the host-facing register file of a network controller. It keeps four 16-bit control/status registers behind two host ports. The host first writes a register number into the select port. Every later access to the data port goes to that register until the select port is written again. Register 0 is the command and status word. Registers 1 and 2 together hold the 24-bit address of the initialization block in memory. Register 3 holds the bus-control options.

Register 0 mixes several kinds of bit. The command bits are set by writing a one. The engine event bits are set by one-cycle pulses from the transmit, receive and DMA logic, and the host clears them by writing a one. The remaining bits are read-only state, and the error and interrupt summaries are derived from the event bits. Registers 1 to 3 are reachable only while the controller is stopped. The block turns each command write into a one-cycle pulse, drives the address and bus-control fields as static outputs, and raises an interrupt line when an event is pending and interrupts are enabled.

Top module: `netctl_csr`

## Requirements
- R1: Port encoding. `host_port`=1 addresses the select port and `host_port`=0 addresses the data port. A write to the select port loads `host_wdata[1:0]` as the register number, and that number stays in force across any number of data accesses. Reading the select port returns the number in bits 1:0, with the upper bits zero. The number is 0 after reset.
- R2: `host_rdata` is registered. In the cycle after a read strobe it shows the addressed value, and it is zero in the cycle after a cycle with no read. A read and a write in the same cycle return the value from before the write.
- R3: Register 0 bits 0 (init), 1 (start), 2 (stop) and 3 (transmit demand) are set by writing one, and writing zero leaves them unchanged. Each bit written as one gives a one-cycle pulse on `cmd_init`, `cmd_start`, `cmd_stop` or `cmd_tdmd` in the following cycle.
- R4: Register 0 bits 8 to 14 are event flags, mapped from `evt_pulse[0..6]` in this order: init done, transmit, receive, memory error, missed frame, heartbeat error, babble. A pulse sets its flag in the next cycle, and writing one to the flag clears it.
- R5: When an event pulse and a host clear hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 15 reads as the OR of bits 11 to 14. Bit 7 (interrupt pending) reads as the OR of bits 8 to 14. `irq` is high exactly when bit 7 and bit 6 are both one.
- R7: Reset and any write with bit 2 set put the block in the stopped state. In that state bit 2 is one, and bits 0, 1, 3, 4 and 5 and all event flags are zero. Stop stays set until a write sets init or start. A start write also sets bit 4 (transmitter on) and bit 5 (receiver on). When stop and start are written together, stop wins.
- R8: The transmit demand bit clears on a transmit event pulse. If a host write sets it in the same cycle as the pulse, the write wins.
- R9: Register 1 holds bits 15:1 of `iblk_addr`, and its bit 0 always reads zero. Register 2 bits 7:0 hold `iblk_addr[23:16]`, and its bits 15:8 are a plain read/write field.
- R10: Register 3 bit 0 drives `bus_hold_ctl`, bit 1 drives `ale_ctl` and bit 2 drives `byte_swap`. Bits 15:3 are plain read/write.
- R11: While the block is not stopped, writes to registers 1 to 3 are ignored and reads of them return zero.
- R12: Register 0 bit 6 (interrupt enable) takes the written value on every register 0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_port | input | 1 | 1 = select port, 0 = data port |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Registered read data |
| evt_pulse | input | 7 | One-cycle engine event pulses |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_tdmd | output | 1 | Transmit demand pulse |
| iblk_addr | output | 24 | Initialization block address |
| bus_hold_ctl | output | 1 | Bus-hold control option |
| ale_ctl | output | 1 | Address-latch control option |
| byte_swap | output | 1 | Byte swap option |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several properties on every cycle. The select number stays put between writes to the select port. The configuration words stay frozen while the block runs, and locked reads return zero. A stop write empties the status word. A pulsed event flag is never lost to a clear in the same cycle. A command pulse agrees with the stop and running state. The bench's scenarios are needed for the exact bit layout of the status word, for a write-one with no effect on a set bit, for the transmit-demand hand-off to a transmit event, and for the return from a running state to stopped, after which registers 1 to 3 open again. A behavioural model compares every output on every cycle through a long random phase.

// File: rtl/netcsr_pkg.sv
package netcsr_pkg;
  localparam int unsigned CSR_W   = 16;
  localparam int unsigned NUM_CSR = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_CSR);
  localparam int unsigned NCFG    = NUM_CSR - 1;
  localparam int unsigned EV_N    = 7;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned AHI_W   = ADDR_W - CSR_W;
  localparam int unsigned CTL_N   = 3;

  // register numbers
  localparam logic [SEL_W-1:0] ID_STAT = SEL_W'(0);

  // status word bit positions
  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_TXON = 4;
  localparam int unsigned B_RXON = 5;
  localparam int unsigned B_INEA = 6;
  localparam int unsigned B_INTR = 7;
  localparam int unsigned B_EV0  = 8;
  localparam int unsigned B_ERR  = 15;

  // event index of the transmit event, first error event
  localparam int unsigned EV_TX    = 1;
  localparam int unsigned EV_ERRLO = 3;

  // writable mask of configuration word k (register k+1)
  function automatic logic [CSR_W-1:0] cfg_mask(input int unsigned k);
    cfg_mask = (k == 0) ? {{(CSR_W-1){1'b1}}, 1'b0} : {CSR_W{1'b1}};
  endfunction
endpackage

// File: rtl/netcsr_status.sv
module netcsr_status
  import netcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic [EV_N-1:0]  evt_i,
  output logic [CSR_W-1:0] word_o,
  output logic             stopped_o,
  output logic [3:0]       cmd_o,
  output logic             irq_o
);
  logic init_q, strt_q, stop_q, tdmd_q, txon_q, rxon_q, inea_q;
  logic init_d, strt_d, stop_d, tdmd_d, txon_d, rxon_d, inea_d;
  logic [EV_N-1:0]  ev_q, ev_d;
  logic [3:0]       cmd_q, cmd_d;
  logic [CSR_W-1:0] wset;
  logic             stop_wr, go_wr, pend, err;
  logic             unused_wbits;

  assign wset    = wr_i ? wdata_i : '0;
  assign stop_wr = wset[B_STOP];
  assign go_wr   = wset[B_INIT] | wset[B_STRT];
  assign unused_wbits = ^{wdata_i[B_TXON], wdata_i[B_RXON], wdata_i[B_INTR], wdata_i[B_ERR]};

  always_comb begin
    init_d = init_q;
    strt_d = strt_q;
    stop_d = stop_q;
    tdmd_d = tdmd_q;
    txon_d = txon_q;
    rxon_d = rxon_q;
    ev_d   = ev_q;
    inea_d = wr_i ? wdata_i[B_INEA] : inea_q;
    cmd_d  = wset[3:0];
    if (stop_wr) begin
      stop_d = 1'b1;
      init_d = 1'b0;
      strt_d = 1'b0;
      tdmd_d = 1'b0;
      txon_d = 1'b0;
      rxon_d = 1'b0;
      ev_d   = '0;
    end else begin
      init_d = init_q | wset[B_INIT];
      strt_d = strt_q | wset[B_STRT];
      if (go_wr) stop_d = 1'b0;
      if (wset[B_STRT]) begin
        txon_d = 1'b1;
        rxon_d = 1'b1;
      end
      tdmd_d = (tdmd_q & ~evt_i[EV_TX]) | wset[B_TDMD];
      ev_d   = evt_i | (ev_q & ~wset[B_EV0 +: EV_N]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      strt_q <= 1'b0;
      stop_q <= 1'b1;
      tdmd_q <= 1'b0;
      txon_q <= 1'b0;
      rxon_q <= 1'b0;
      inea_q <= 1'b0;
      ev_q   <= '0;
      cmd_q  <= '0;
    end else begin
      init_q <= init_d;
      strt_q <= strt_d;
      stop_q <= stop_d;
      tdmd_q <= tdmd_d;
      txon_q <= txon_d;
      rxon_q <= rxon_d;
      inea_q <= inea_d;
      ev_q   <= ev_d;
      cmd_q  <= cmd_d;
    end
  end

  assign pend      = |ev_q;
  assign err       = |ev_q[EV_N-1:EV_ERRLO];
  assign word_o    = {err, ev_q, pend, inea_q, rxon_q, txon_q, tdmd_q, stop_q, strt_q, init_q};
  assign stopped_o = stop_q;
  assign cmd_o     = cmd_q;
  assign irq_o     = pend & inea_q;

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_wr |=> (stop_q && !txon_q && !rxon_q && !tdmd_q && ev_q == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ((evt_i != '0) && !stop_wr) |=> ((ev_q & $past(evt_i)) == $past(evt_i)));

  assert_stop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_q[B_STOP] |-> stop_q);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q[B_STRT] && !cmd_q[B_STOP]) |-> (!stop_q && txon_q && rxon_q));

  assert_init_kept_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !stop_wr |=> (init_q || !$past(init_q)));
endmodule

// File: rtl/netcsr_cfg.sv
module netcsr_cfg
  import netcsr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [SEL_W-1:0]           idx_i,
  input  logic [CSR_W-1:0]           wdata_i,
  input  logic                       stopped_i,
  output logic [NCFG-1:0][CSR_W-1:0] words_o
);
  for (genvar g = 0; g < NCFG; g++) begin : g_word
    localparam logic [CSR_W-1:0] MASK = cfg_mask(g);
    logic [CSR_W-1:0] q, d;
    logic             en;

    assign en = wr_i && stopped_i && (idx_i == SEL_W'(g + 1));

    always_comb d = en ? (wdata_i & MASK) : q;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= d;
    end

    assign words_o[g] = q;
  end

  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !stopped_i |=> $stable(words_o));
endmodule

// File: rtl/netcsr_rdmux.sv
module netcsr_rdmux
  import netcsr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic                       port_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic                       stopped_i,
  input  logic [CSR_W-1:0]           stat_i,
  input  logic [NCFG-1:0][CSR_W-1:0] cfg_i,
  output logic [CSR_W-1:0]           rdata_o
);
  logic [CSR_W-1:0] rd_d, rd_q, cfg_pick;

  always_comb begin
    cfg_pick = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (sel_i == SEL_W'(k + 1)) cfg_pick = cfg_i[k];
    end
  end

  always_comb begin
    rd_d = '0;
    if (rd_i) begin
      if (port_i)                rd_d = CSR_W'(sel_i);
      else if (sel_i == ID_STAT) rd_d = stat_i;
      else if (stopped_i)        rd_d = cfg_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
  import netcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_port,
  input  logic [CSR_W-1:0]  host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [CSR_W-1:0]  host_rdata,
  input  logic [EV_N-1:0]   evt_pulse,
  output logic              cmd_init,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_tdmd,
  output logic [ADDR_W-1:0] iblk_addr,
  output logic              bus_hold_ctl,
  output logic              ale_ctl,
  output logic              byte_swap,
  output logic              irq
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_int_n;
  logic [SEL_W-1:0]           sel_q, sel_d;
  logic                       sel_wr, data_wr, stat_wr, stopped;
  logic [CSR_W-1:0]           stat_word;
  logic [NCFG-1:0][CSR_W-1:0] cfg_words;
  logic [3:0]                 cmd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel_wr  = host_wr & host_port;
  assign data_wr = host_wr & ~host_port;
  assign stat_wr = data_wr & (sel_q == ID_STAT);

  always_comb sel_d = sel_wr ? host_wdata[SEL_W-1:0] : sel_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  sel_q <= '0;
    else if (sel_wr) sel_q <= sel_d;
  end

  netcsr_status u_status (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_i      (stat_wr),
    .wdata_i   (host_wdata),
    .evt_i     (evt_pulse),
    .word_o    (stat_word),
    .stopped_o (stopped),
    .cmd_o     (cmd),
    .irq_o     (irq)
  );

  netcsr_cfg u_cfg (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_i      (data_wr),
    .idx_i     (sel_q),
    .wdata_i   (host_wdata),
    .stopped_i (stopped),
    .words_o   (cfg_words)
  );

  netcsr_rdmux u_rdmux (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .rd_i      (host_rd),
    .port_i    (host_port),
    .sel_i     (sel_q),
    .stopped_i (stopped),
    .stat_i    (stat_word),
    .cfg_i     (cfg_words),
    .rdata_o   (host_rdata)
  );

  assign cmd_init     = cmd[B_INIT];
  assign cmd_start    = cmd[B_STRT];
  assign cmd_stop     = cmd[B_STOP];
  assign cmd_tdmd     = cmd[B_TDMD];
  assign iblk_addr    = {cfg_words[1][AHI_W-1:0], cfg_words[0]};
  assign bus_hold_ctl = cfg_words[NCFG-1][0];
  assign ale_ctl      = cfg_words[NCFG-1][1];
  assign byte_swap    = cfg_words[NCFG-1][2];

  assert_sel_sticky_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sel_wr |=> $stable(sel_q));

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_wr |=> (sel_q == $past(host_wdata[SEL_W-1:0])));

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !host_rd |=> (host_rdata == '0));

  assert_locked_read_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_rd && !host_port && sel_q != ID_STAT && !stopped) |=> (host_rdata == '0));

  assert_irq_pending_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (stat_word[B_EV0 +: EV_N] != '0));
endmodule

// File: tb/netctl_csr_bench.sv
module netctl_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_port = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        cmd_init, cmd_start, cmd_stop, cmd_tdmd;
  logic [23:0] iblk_addr;
  logic        bus_hold_ctl, ale_ctl, byte_swap, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  netctl_csr u_netctl_csr (
    .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .evt_pulse(evt_pulse), .cmd_init(cmd_init), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_tdmd(cmd_tdmd), .iblk_addr(iblk_addr),
    .bus_hold_ctl(bus_hold_ctl), .ale_ctl(ale_ctl), .byte_swap(byte_swap), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_sel;
  bit          m_init, m_strt, m_stop, m_tdmd, m_txon, m_rxon, m_inea;
  bit [6:0]    m_ev;
  bit [15:0]   m_r1, m_r2, m_r3, m_rdata;
  bit [3:0]    m_cmd;
  bit          m_p0, m_p1;

  function automatic bit [15:0] m_word0();
    bit [15:0] w;
    w = '0;
    w[0] = m_init; w[1] = m_strt; w[2] = m_stop; w[3] = m_tdmd;
    w[4] = m_txon; w[5] = m_rxon; w[6] = m_inea;
    w[7] = (m_ev != 0);
    w[14:8] = m_ev;
    w[15] = (m_ev[6:3] != 0);
    return w;
  endfunction

  task automatic m_clear();
    m_sel = 0; m_init = 0; m_strt = 0; m_stop = 1; m_tdmd = 0;
    m_txon = 0; m_rxon = 0; m_inea = 0; m_ev = 0;
    m_r1 = 0; m_r2 = 0; m_r3 = 0; m_rdata = 0; m_cmd = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p0 = 0; m_p1 = 0;
      m_clear();
    end else if (!m_p1) begin
      m_clear();
      m_p1 = m_p0; m_p0 = 1;
    end else begin
      bit [15:0] rv;
      bit        w0, wc;
      rv = 0;
      if (host_rd) begin
        if (host_port)      rv = 16'(m_sel);
        else if (m_sel == 0) rv = m_word0();
        else if (m_stop)    rv = (m_sel == 1) ? m_r1 : (m_sel == 2) ? m_r2 : m_r3;
      end
      w0 = host_wr && !host_port && m_sel == 0;
      wc = host_wr && !host_port && m_sel != 0 && m_stop;
      m_rdata = rv;
      m_cmd = w0 ? host_wdata[3:0] : 4'd0;
      if (wc) begin
        if (m_sel == 1)      m_r1 = host_wdata & 16'hFFFE;
        else if (m_sel == 2) m_r2 = host_wdata;
        else                 m_r3 = host_wdata;
      end
      if (w0) m_inea = host_wdata[6];
      if (w0 && host_wdata[2]) begin
        m_stop = 1; m_init = 0; m_strt = 0; m_tdmd = 0; m_txon = 0; m_rxon = 0; m_ev = 0;
      end else begin
        if (w0 && host_wdata[0]) m_init = 1;
        if (w0 && host_wdata[1]) begin m_strt = 1; m_txon = 1; m_rxon = 1; end
        if (w0 && (host_wdata[0] || host_wdata[1])) m_stop = 0;
        if (evt_pulse[1]) m_tdmd = 0;
        if (w0 && host_wdata[3]) m_tdmd = 1;
        if (w0) m_ev = m_ev & ~host_wdata[14:8];
        m_ev = m_ev | evt_pulse;
      end
      if (host_wr && host_port) m_sel = int'(host_wdata[1:0]);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2", "rdata", 32'(host_rdata), 32'(m_rdata));
      chk("R3", "cmd", 32'({cmd_tdmd, cmd_stop, cmd_start, cmd_init}), 32'(m_cmd));
      chk("R6", "irq", 32'(irq), 32'(m_inea && m_ev != 0));
      chk("R9", "iblk_addr", 32'(iblk_addr), 32'({m_r2[7:0], m_r1}));
      chk("R10", "ctl", 32'({byte_swap, ale_ctl, bus_hold_ctl}), 32'(m_r3[2:0]));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_wr(input bit p, input logic [15:0] d);
    @(negedge clk); host_port = p; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic do_rd(input bit p, output logic [15:0] v);
    @(negedge clk); host_port = p; host_rd = 1;
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    do_rd(0, v); chk("R7", "reset status", 32'(v), 32'h0004);
    do_rd(1, v); chk("R1", "reset select", 32'(v), 32'h0000);
    do_wr(1, 16'hFFF1);
    do_rd(1, v); chk("R1", "select readback", 32'(v), 32'h0001);
    do_wr(0, 16'h1235);
    do_rd(0, v); chk("R9", "reg1 bit0 zero", 32'(v), 32'h1234);
    do_rd(0, v); chk("R1", "select sticky", 32'(v), 32'h1234);
    do_wr(1, 16'h0002); do_wr(0, 16'hAB12);
    do_rd(0, v); chk("R9", "reg2 readback", 32'(v), 32'hAB12);
    chk("R9", "address out", 32'(iblk_addr), 32'h121234);
    do_wr(1, 16'h0003); do_wr(0, 16'hFFFD);
    do_rd(0, v); chk("R10", "reg3 readback", 32'(v), 32'hFFFD);
    chk("R10", "ctl pins", 32'({byte_swap, ale_ctl, bus_hold_ctl}), 32'h5);

    do_wr(1, 16'h0000); do_wr(0, 16'h0042);
    do_rd(0, v); chk("R12", "start with enable", 32'(v), 32'h0072);
    do_wr(1, 16'h0001); do_wr(0, 16'hFFFF);
    do_rd(0, v); chk("R11", "locked read", 32'(v), 32'h0000);
    chk("R11", "locked write", 32'(iblk_addr), 32'h121234);
    do_wr(1, 16'h0000);

    pulse(7'b0001000);
    do_rd(0, v); chk("R6", "memory error summary", 32'(v), 32'h88F2);
    chk("R6", "irq high", 32'(irq), 32'h1);
    do_wr(0, 16'h0840);
    do_rd(0, v); chk("R4", "clear memory error", 32'(v), 32'h0072);

    @(negedge clk); host_port = 0; host_wdata = 16'h0440; host_wr = 1; evt_pulse = 7'b0000100;
    @(negedge clk); host_wr = 0; evt_pulse = '0;
    do_rd(0, v); chk("R5", "event beats clear", 32'(v), 32'h04F2);

    do_wr(0, 16'h0048);
    do_rd(0, v); chk("R3", "demand set", 32'(v), 32'h04FA);
    pulse(7'b0000010);
    do_rd(0, v); chk("R8", "demand cleared by tx event", 32'(v), 32'h06F2);
    do_wr(0, 16'h0040);
    do_rd(0, v); chk("R3", "zero write no effect", 32'(v), 32'h06F2);

    do_wr(0, 16'h0046);
    do_rd(0, v); chk("R7", "stop wins over start", 32'(v), 32'h0044);
    chk("R7", "irq after stop", 32'(irq), 32'h0);
    do_wr(1, 16'h0001);
    do_rd(0, v); chk("R11", "unlocked after stop", 32'(v), 32'h1234);
    do_wr(1, 16'h0000); do_wr(0, 16'h0001);
    do_rd(0, v); chk("R7", "init leaves stop", 32'(v), 32'h0001);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      host_port  = ($urandom % 5) == 0;
      host_wdata = 16'($urandom);
      if (($urandom % 4) != 0) host_wdata[2] = 1'b0;
      host_wr    = ($urandom % 3) == 0;
      host_rd    = ($urandom % 2) == 0;
      evt_pulse  = (($urandom % 3) == 0) ? 7'($urandom) : 7'd0;
    end
    @(negedge clk); host_wr = 0; host_rd = 0; evt_pulse = '0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule